// File: doc/BRIEF.md
# Sequential Combination Lock

This block is a small synchronous state machine that opens only when three dial operations arrive in a fixed order. Each operation is a turn direction (right or left) together with a dial position from 0 to 31. It is presented on the clock edge where a one-cycle valid strobe is high. The machine records how far the entered sequence has correctly advanced. Its open flag is raised once the last step has been accepted.

The fixed combination is right-13, then left-22, then right-3. The direction is as significant as the number, and the steps must come in this order. Any valid operation that breaks the sequence sends the machine back to its starting point. There is one exception: right-13 always begins a new attempt, so it lands on the first-step state whatever state the machine was in. Once the lock is open, the next valid operation locks it again and is treated as the first step of a new attempt. The two state bits are driven onto a debug output so that the current progress is visible.

Top module: `combo_lock_fsm`

## Requirements
- R1: While `rst` is high on a rising edge, the state becomes 2'b00 (closed, no progress) and `lock_open` is 0. The state encoding on `state_dbg` is 00 = no progress, 01 = first step done, 10 = second step done, 11 = open.
- R2: On an edge where `op_valid` is 0, the state does not change, whatever `op_dir` and `op_num` carry.
- R3: A valid operation with `op_dir`=0 (right) and `op_num`=13 moves the state to 01 from every state, including 11.
- R4: From state 01, a valid operation with `op_dir`=1 (left) and `op_num`=22 moves the state to 10.
- R5: From state 10, a valid operation with `op_dir`=0 (right) and `op_num`=3 moves the state to 11.
- R6: From a closed state (00, 01 or 10), a valid operation that is neither the expected next step nor right-13 moves the state to 00.
- R7: `lock_open` is 1 exactly when the state is 11. It rises only on the edge after the state was 10.
- R8: From state 11, a valid operation other than right-13 moves the state to 00 and drops `lock_open`.
- R9: Order and direction both matter. A correct value with the wrong direction does not advance the state: left-13 from 00, right-22 from 01, and left-3 from 10 all go to 00. A step given out of order does not advance the state either: left-22 from 00 and right-3 from 01 both go to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe qualifying a dial operation |
| op_dir | input | 1 | Turn direction: 0 = right, 1 = left |
| op_num | input | 5 | Dial position 0..31 |
| lock_open | output | 1 | High while the lock is open |
| state_dbg | output | 2 | Current state encoding |

## Verification
The assertions assume that `op_dir` and `op_num` are known (not X) on every edge where `op_valid` is high, and that reset is applied synchronously for at least one edge before operations begin. The bench changes inputs only on falling edges, so every operation is stable across the rising edge that samples it. The stimulus includes operations that carry garbage on the direction and number while valid is low; these check that unqualified data is ignored. It also covers near-miss values that differ only in direction or only in number from a correct step.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

    localparam int NUM_W   = 5;
    localparam int STEPS   = 3;
    localparam int STATE_W = $clog2(STEPS + 1);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_t;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } turn_dir_t;

    typedef struct packed {
        turn_dir_t          dir;
        logic [NUM_W-1:0]   num;
    } dial_op_t;

    function automatic logic op_matches(dial_op_t a, dial_op_t b);
        return (a.dir == b.dir) && (a.num == b.num);
    endfunction

endpackage

// File: rtl/lockseq_step_match.sv
module lockseq_step_match
    import lockseq_pkg::*;
#(
    parameter logic              DIR0 = 1'b0,
    parameter logic [NUM_W-1:0]  NUM0 = 5'd13,
    parameter logic              DIR1 = 1'b1,
    parameter logic [NUM_W-1:0]  NUM1 = 5'd22,
    parameter logic              DIR2 = 1'b0,
    parameter logic [NUM_W-1:0]  NUM2 = 5'd3
) (
    input  dial_op_t            op,
    output logic [STEPS-1:0]    step_hit
);
    localparam logic [STEPS-1:0]       DIR_TBL = {DIR2, DIR1, DIR0};
    localparam logic [STEPS*NUM_W-1:0] NUM_TBL = {NUM2, NUM1, NUM0};

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        dial_op_t ref_op;
        assign ref_op.dir = turn_dir_t'(DIR_TBL[g]);
        assign ref_op.num = NUM_TBL[g*NUM_W +: NUM_W];
        assign step_hit[g] = op_matches(op, ref_op);
    end

endmodule

// File: rtl/lockseq_next_state.sv
module lockseq_next_state
    import lockseq_pkg::*;
(
    input  lock_state_t         cur,
    input  logic                valid,
    input  logic [STEPS-1:0]    step_hit,
    output lock_state_t         nxt
);
    always_comb begin
        nxt = cur;
        if (valid) begin
            if (step_hit[0]) begin
                nxt = ST_ONE;
            end else begin
                unique case (cur)
                    ST_ONE:  nxt = step_hit[1] ? ST_TWO  : ST_IDLE;
                    ST_TWO:  nxt = step_hit[2] ? ST_OPEN : ST_IDLE;
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/lockseq_state_reg.sv
module lockseq_state_reg
    import lockseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lock_state_t nxt,
    output lock_state_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> cur == ST_IDLE);

endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
    import lockseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic               op_dir,
    input  logic [NUM_W-1:0]   op_num,
    output logic               lock_open,
    output logic [STATE_W-1:0] state_dbg
);
    dial_op_t          op;
    logic [STEPS-1:0]  hit;
    lock_state_t       cur_st;
    lock_state_t       nxt_st;

    assign op.dir = turn_dir_t'(op_dir);
    assign op.num = op_num;

    lockseq_step_match u_match (
        .op       (op),
        .step_hit (hit)
    );

    lockseq_next_state u_next (
        .cur      (cur_st),
        .valid    (op_valid),
        .step_hit (hit),
        .nxt      (nxt_st)
    );

    lockseq_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    assign lock_open = (cur_st == ST_OPEN);
    assign state_dbg = cur_st;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(state_dbg));

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_dir && op_num == 5'd13) |=> state_dbg == 2'b01);

    assert_second_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && state_dbg == 2'b01 && op_dir && op_num == 5'd22)
        |=> state_dbg == 2'b10);

    assert_third_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && state_dbg == 2'b10 && !op_dir && op_num == 5'd3)
        |=> state_dbg == 2'b11);

    assert_open_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_open) |-> $past(state_dbg) == 2'b10);

    assert_relock_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && state_dbg == 2'b11 && !(!op_dir && op_num == 5'd13))
        |=> (state_dbg == 2'b00 && !lock_open));

    assert_wrong_dir_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && state_dbg == 2'b00 && op_dir && op_num == 5'd13)
        |=> state_dbg == 2'b00);

endmodule

// File: tb/test_combo_lock_fsm.sv
module test_combo_lock_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [4:0] op_num = 5'd0;
    logic       lock_open;
    logic [1:0] state_dbg;

    int compared = 0;
    int mismatched = 0;
    int progress = 0;
    bit done = 0;

    int seq_dir [3] = '{0, 1, 0};
    int seq_num [3] = '{13, 22, 3};

    always #4 clk = ~clk;

    combo_lock_fsm i_combo_lock_fsm (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_dir    (op_dir),
        .op_num    (op_num),
        .lock_open (lock_open),
        .state_dbg (state_dbg)
    );

    function automatic int model_next(int p, bit v, bit d, int n, bit r);
        if (r) return 0;
        if (!v) return p;
        if (d == seq_dir[0] && n == seq_num[0]) return 1;
        if (p < 3 && d == seq_dir[p] && n == seq_num[p]) return p + 1;
        return 0;
    endfunction

    task automatic compare(string tag);
        compared++;
        if (state_dbg !== 2'(progress) || lock_open !== (progress == 3)) begin
            mismatched++;
            $display("FAIL %s: state=%0d open=%0b expected state=%0d open=%0b",
                     tag, state_dbg, lock_open, progress, progress == 3);
        end
    endtask

    task automatic step(bit v, bit d, int n, string tag);
        op_valid = v; op_dir = d; op_num = 5'(n);
        @(posedge clk);
        #1 progress = model_next(progress, v, d, n, rst);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        step(1'b1, 1'b0, 13, tag);
        step(1'b0, 1'b0, 0, tag);
        rst = 1'b0;
    endtask

    initial begin
        #1600000;
        mismatched++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1 reset");
        // full sequence, R3 R4 R5 R7
        step(1, 0, 13, "R3 first step");
        step(1, 1, 22, "R4 second step");
        step(1, 0, 3,  "R5 third step / R7 open");
        // hold with garbage while invalid, R2
        step(0, 1, 31, "R2 hold open");
        step(0, 0, 13, "R2 hold open r13 unqualified");
        // relock from open, R8
        step(1, 1, 5,  "R8 relock");
        // R2 in partial states
        step(1, 0, 13, "R3 from idle");
        step(0, 1, 22, "R2 hold one");
        step(1, 1, 22, "R4");
        step(0, 0, 3,  "R2 hold two");
        // restart from C, R3
        step(1, 0, 13, "R3 restart from two");
        // wrong direction, R9
        step(1, 0, 22, "R9 right22 from one");
        step(1, 1, 13, "R9 left13 from idle");
        step(1, 1, 22, "R9 left22 out of order");
        step(1, 0, 13, "R3");
        step(1, 0, 3,  "R9 right3 from one");
        step(1, 0, 13, "R3");
        step(1, 1, 22, "R4");
        step(1, 1, 3,  "R9 left3 from two");
        // wrong number from C, R6
        step(1, 0, 13, "R3");
        step(1, 1, 22, "R4");
        step(1, 0, 4,  "R6 wrong num from two");
        step(1, 0, 13, "R3");
        step(1, 1, 21, "R6 wrong num from one");
        step(1, 0, 0,  "R6 from idle");
        // open then R13 goes straight to one, R3
        step(1, 0, 13, "R3");
        step(1, 1, 22, "R4");
        step(1, 0, 3,  "R5 / R7");
        step(1, 0, 13, "R3 from open");
        step(1, 1, 22, "R4");
        step(1, 0, 3,  "R5");
        step(1, 0, 3,  "R8 right3 relocks");
        // reset from open, R1
        step(1, 0, 13, "R3");
        step(1, 1, 22, "R4");
        step(1, 0, 3,  "R5");
        do_reset("R1 reset from open");
        // sweep near-miss values from idle
        for (int k = 0; k < 32; k++) begin
            if (k != 13) step(1, 0, k, "R6 sweep idle");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule